// File: doc/BRIEF.md
# Set-Associative Address Translator with Table Walk

This block turns a 14-bit virtual address into a 12-bit physical address, using 64-byte pages. A small 16-entry translation cache is organised as 4 sets of 4 ways. When the cache holds the page, it answers in the same cycle as the request. When it does not, the block reads a flat 256-entry page table on the next cycle. That table sits inside the block and is loaded through its own write port. If the table entry is present, the translation is returned and stored in the cache. If the entry is absent, a page fault is reported and the cache is left as it was.

A requester presents `req_va` with `req_valid` high while `busy` is low. A cached translation comes back combinationally with `rsp_hit` set. After a miss, `busy` rises for exactly one cycle, and in that cycle the response carries either the page table result or `rsp_fault`. A `flush` pulse invalidates every cached translation at once.

Top module: `tlb_xlate`

## Requirements
- R1: The page number is `req_va[13:6]` and the page offset is `req_va[5:0]`. The physical address is `{ppn, offset}`, with a 6-bit ppn in bits 11:6 and the offset unchanged in bits 5:0.
- R2: The cache set is page number bits 1:0 and the tag is page number bits 7:2. A valid way whose tag matches gives, in the request cycle, `rsp_valid`=1, `rsp_hit`=1, `rsp_fault`=0 and the cached ppn.
- R3: On a miss, `rsp_valid` is 0 in the request cycle. In the following cycle `busy`=1, `rsp_valid`=1 and `rsp_hit`=0, and the response comes from the page table. `busy` is then 0 again.
- R4: A page table entry with its present bit clear makes the walk cycle show `rsp_fault`=1. The cache is not changed, so the same address misses again.
- R5: A present page table entry gives the stored ppn in the walk cycle and is written into the indexed set, so the next request for that page hits.
- R6: A fill goes to the lowest-numbered invalid way of the indexed set.
- R7: When the indexed set has no invalid way, the fill replaces the way named by that set's round-robin pointer. The pointer starts at 0 after reset and advances by one, modulo 4, after each such replacement.
- R8: A `flush` cycle clears every cached valid bit at the next edge. It suppresses any fill in the same cycle and leaves the round-robin pointers as they are.
- R9: When `pt_we` is high, page table entry `pt_widx` takes `pt_wppn` and present bit `pt_wvalid`. Reset marks every page table entry and cache entry absent.
- R10: A request presented while `busy` is high is ignored. `rsp_hit` and `rsp_fault` are never high together.
- R11: A hit returns the cached ppn even after the page table entry has been rewritten, because no table read takes place on a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all cached translations |
| pt_we | input | 1 | Page table write enable |
| pt_widx | input | 8 | Page table entry to write |
| pt_wppn | input | 6 | Physical page number to store |
| pt_wvalid | input | 1 | Present bit to store |
| req_valid | input | 1 | Translation request |
| req_va | input | 14 | Virtual address |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_hit | output | 1 | Response came from the cache |
| rsp_fault | output | 1 | Page table entry absent |
| rsp_ppn | output | 6 | Physical page number |
| rsp_pa | output | 12 | Physical address |
| busy | output | 1 | Table walk cycle; requests ignored |

## Verification
The assertions assume that a requester holding `req_valid` while `busy` is high is not waiting for an answer to that request, and that a flush may arrive in any cycle, including a walk cycle. The check that at most one way matches depends on no translation being fetched twice, which holds because only one walk can be outstanding. The stimulus presents new requests only on cycles when `busy` is low. It drives extra requests into walk cycles only on purpose, to show they are ignored. It limits random page numbers to a small range so that sets fill up and round-robin replacement takes place.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W     = 14;
  localparam int PA_W     = 12;
  localparam int OFF_W    = 6;
  localparam int SETS     = 4;
  localparam int WAYS     = 4;
  localparam int VPN_W    = VA_W - OFF_W;
  localparam int PPN_W    = PA_W - OFF_W;
  localparam int SET_W    = $clog2(SETS);
  localparam int WAY_W    = $clog2(WAYS);
  localparam int TAG_W    = VPN_W - SET_W;
  localparam int PT_DEPTH = 1 << VPN_W;
  localparam int ENTRIES  = SETS * WAYS;

  typedef logic [VA_W-1:0]  va_t;
  typedef logic [PA_W-1:0]  pa_t;
  typedef logic [OFF_W-1:0] off_t;
  typedef logic [VPN_W-1:0] vpn_t;
  typedef logic [PPN_W-1:0] ppn_t;
  typedef logic [SET_W-1:0] set_t;
  typedef logic [TAG_W-1:0] tag_t;
  typedef logic [WAY_W-1:0] way_t;

  typedef struct packed {
    logic present;
    ppn_t ppn;
  } pte_t;

  function automatic vpn_t va_page(va_t va);
    return va[VA_W-1:OFF_W];
  endfunction

  function automatic off_t va_offset(va_t va);
    return va[OFF_W-1:0];
  endfunction

  function automatic set_t page_set(vpn_t vpn);
    return vpn[SET_W-1:0];
  endfunction

  function automatic tag_t page_tag(vpn_t vpn);
    return vpn[VPN_W-1:SET_W];
  endfunction

  function automatic pa_t join_pa(ppn_t ppn, off_t off);
    return {ppn, off};
  endfunction

  // returns {found, way}; the lowest free way wins
  function automatic logic [WAY_W:0] first_free(logic [WAYS-1:0] vld);
    logic [WAY_W:0] pick;
    pick = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!vld[i]) pick = {1'b1, way_t'(i)};
    end
    return pick;
  endfunction
endpackage

// File: rtl/tlb_ptable.sv
module tlb_ptable
  import tlb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic we,
  input  vpn_t widx,
  input  pte_t wdata,
  input  vpn_t ridx,
  output pte_t rdata
);
  pte_t mem_q [PT_DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PT_DEPTH; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q[widx] <= wdata;
    end
  end

  assign rdata = mem_q[ridx];
endmodule

// File: rtl/tlb_array.sv
module tlb_array
  import tlb_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  set_t               lk_set,
  input  tag_t               lk_tag,
  output logic               lk_hit,
  output ppn_t               lk_ppn,
  output logic [WAYS-1:0]    lk_hit_vec,
  input  logic               fill_en,
  input  set_t               fill_set,
  input  tag_t               fill_tag,
  input  ppn_t               fill_ppn,
  output logic [ENTRIES-1:0] vld_bits
);
  tag_t            tag_q [SETS][WAYS];
  ppn_t            ppn_q [SETS][WAYS];
  logic [WAYS-1:0] vld_q [SETS];
  way_t            rr_q  [SETS];

  // lookup compare per way
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign lk_hit_vec[w] = vld_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
  end

  always_comb begin
    lk_ppn = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (lk_hit_vec[w]) lk_ppn = lk_ppn | ppn_q[lk_set][w];
    end
  end

  assign lk_hit = |lk_hit_vec;

  for (genvar s = 0; s < SETS; s++) begin : g_vld
    assign vld_bits[s*WAYS +: WAYS] = vld_q[s];
  end

  // victim choice: free way first, round-robin otherwise
  logic [WAY_W:0] free_pick;
  logic           free_ok;
  way_t           victim;

  assign free_pick = first_free(vld_q[fill_set]);
  assign free_ok   = free_pick[WAY_W];
  assign victim    = free_ok ? free_pick[WAY_W-1:0] : rr_q[fill_set];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        rr_q[s]  <= '0;
      end
    end else if (flush) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else if (fill_en) begin
      vld_q[fill_set][victim] <= 1'b1;
      if (!free_ok) rr_q[fill_set] <= way_t'(rr_q[fill_set] + 1'b1);
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en && !flush) begin
      tag_q[fill_set][victim] <= fill_tag;
      ppn_q[fill_set][victim] <= fill_ppn;
    end
  end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             pt_we,
  input  logic [VPN_W-1:0] pt_widx,
  input  logic [PPN_W-1:0] pt_wppn,
  input  logic             pt_wvalid,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_va,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_fault,
  output logic [PPN_W-1:0] rsp_ppn,
  output logic [PA_W-1:0]  rsp_pa,
  output logic             busy
);
  logic walk_q;
  va_t  walk_va_q;

  // named internal events
  logic               idle_req;
  logic               tlb_hit;
  ppn_t               tlb_ppn;
  logic [WAYS-1:0]    tlb_hit_vec;
  logic [ENTRIES-1:0] tlb_vld_bits;
  logic               walk_start;
  logic               fill_en;
  pte_t               walk_pte;
  vpn_t               walk_vpn;
  vpn_t               req_vpn;
  ppn_t               out_ppn;
  off_t               out_off;

  assign req_vpn    = va_page(req_va);
  assign walk_vpn   = va_page(walk_va_q);
  assign idle_req   = req_valid && !walk_q;
  assign walk_start = idle_req && !tlb_hit;
  assign fill_en    = walk_q && walk_pte.present && !flush;

  tlb_array u_array (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .lk_set     (page_set(req_vpn)),
    .lk_tag     (page_tag(req_vpn)),
    .lk_hit     (tlb_hit),
    .lk_ppn     (tlb_ppn),
    .lk_hit_vec (tlb_hit_vec),
    .fill_en    (fill_en),
    .fill_set   (page_set(walk_vpn)),
    .fill_tag   (page_tag(walk_vpn)),
    .fill_ppn   (walk_pte.ppn),
    .vld_bits   (tlb_vld_bits)
  );

  tlb_ptable u_ptable (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (pt_we),
    .widx  (pt_widx),
    .wdata ('{present: pt_wvalid, ppn: pt_wppn}),
    .ridx  (walk_vpn),
    .rdata (walk_pte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      walk_q    <= 1'b0;
      walk_va_q <= '0;
    end else begin
      walk_q <= walk_start;
      if (walk_start) walk_va_q <= req_va;
    end
  end

  assign out_ppn   = walk_q ? walk_pte.ppn : tlb_ppn;
  assign out_off   = walk_q ? va_offset(walk_va_q) : va_offset(req_va);
  assign rsp_valid = walk_q || (idle_req && tlb_hit);
  assign rsp_hit   = idle_req && tlb_hit;
  assign rsp_fault = walk_q && !walk_pte.present;
  assign rsp_ppn   = rsp_valid ? out_ppn : '0;
  assign rsp_pa    = rsp_valid ? join_pa(out_ppn, out_off) : '0;
  assign busy      = walk_q;
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk
  import tlb_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               flush,
  input logic               req_valid,
  input logic [VA_W-1:0]    req_va,
  input logic               rsp_valid,
  input logic               rsp_hit,
  input logic               rsp_fault,
  input logic [PA_W-1:0]    rsp_pa,
  input logic               busy,
  input logic [WAYS-1:0]    hit_vec,
  input logic [ENTRIES-1:0] vld_bits
);
  a_r2_hit_offset: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> (rsp_valid && rsp_pa[OFF_W-1:0] == req_va[OFF_W-1:0]));

  a_r2_single_way: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  a_r3_miss_walks: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && !rsp_valid) |=> (busy && rsp_valid && !rsp_hit));

  a_r3_walk_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);

  a_r4_fault_keeps_tlb: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault && !flush) |=> $stable(vld_bits));

  a_r8_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (vld_bits == '0));

  a_r10_hit_fault_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_hit && rsp_fault));
endmodule

bind tlb_xlate tlb_xlate_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .flush     (flush),
  .req_valid (req_valid),
  .req_va    (req_va),
  .rsp_valid (rsp_valid),
  .rsp_hit   (rsp_hit),
  .rsp_fault (rsp_fault),
  .rsp_pa    (rsp_pa),
  .busy      (busy),
  .hit_vec   (tlb_hit_vec),
  .vld_bits  (tlb_vld_bits)
);

// File: tb/tlb_xlate_tb.sv
module tlb_xlate_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        pt_we = 1'b0;
  logic [7:0]  pt_widx = '0;
  logic [5:0]  pt_wppn = '0;
  logic        pt_wvalid = 1'b0;
  logic        req_valid = 1'b0;
  logic [13:0] req_va = '0;
  logic        rsp_valid, rsp_hit, rsp_fault, busy;
  logic [5:0]  rsp_ppn;
  logic [11:0] rsp_pa;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  // reference model state
  int  m_tag [4][4];
  int  m_ppn [4][4];
  bit  m_vld [4][4];
  int  m_rr  [4];
  int  p_ppn [256];
  bit  p_vld [256];

  always #4 clk = ~clk;

  tlb_xlate u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .pt_we(pt_we), .pt_widx(pt_widx), .pt_wppn(pt_wppn), .pt_wvalid(pt_wvalid),
    .req_valid(req_valid), .req_va(req_va),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
    .rsp_ppn(rsp_ppn), .rsp_pa(rsp_pa), .busy(busy)
  );

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_pa(int ppn, int va);
    return (ppn * 64) + (va % 64);
  endfunction

  task automatic pt_write(int idx, int ppn, bit v);
    @(negedge clk);
    pt_we = 1'b1; pt_widx = idx[7:0]; pt_wppn = ppn[5:0]; pt_wvalid = v;
    @(negedge clk);
    pt_we = 1'b0;
    p_ppn[idx] = ppn; p_vld[idx] = v;
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    for (int s = 0; s < 4; s++) for (int w = 0; w < 4; w++) m_vld[s][w] = 0;
  endtask

  // one request; optionally an intruding request or a flush in the walk cycle
  task automatic access(int va, int intr_va, bit flush_walk, output bit was_hit);
    int vpn, s, t, hw, vw;
    vpn = va / 64; s = vpn % 4; t = vpn / 4; hw = -1;
    for (int w = 0; w < 4; w++) if (m_vld[s][w] && m_tag[s][w] == t) hw = w;
    @(negedge clk);
    req_valid = 1'b1; req_va = va[13:0];
    #1;
    if (hw >= 0) begin
      was_hit = 1;
      chk("R2 hit valid", int'(rsp_valid), 1);
      chk("R2 hit flag", int'(rsp_hit), 1);
      chk("R10 no fault on hit", int'(rsp_fault), 0);
      chk("R2 ppn", int'(rsp_ppn), m_ppn[s][hw]);
      chk("R1 pa", int'(rsp_pa), exp_pa(m_ppn[s][hw], va));
      @(negedge clk);
      req_valid = 1'b0;
    end else begin
      was_hit = 0;
      chk("R3 no response on miss cycle", int'(rsp_valid), 0);
      @(negedge clk);
      if (intr_va >= 0) begin
        req_valid = 1'b1; req_va = intr_va[13:0];
      end else begin
        req_valid = 1'b0;
      end
      flush = flush_walk;
      #1;
      chk("R3 busy", int'(busy), 1);
      chk("R3 walk valid", int'(rsp_valid), 1);
      chk("R3 walk not hit", int'(rsp_hit), 0);
      chk("R4 fault flag", int'(rsp_fault), p_vld[vpn] ? 0 : 1);
      if (p_vld[vpn]) chk("R5 walk pa", int'(rsp_pa), exp_pa(p_ppn[vpn], va));
      if (flush_walk) begin
        for (int a = 0; a < 4; a++) for (int w = 0; w < 4; w++) m_vld[a][w] = 0;
      end else if (p_vld[vpn]) begin
        vw = -1;
        for (int w = 3; w >= 0; w--) if (!m_vld[s][w]) vw = w;
        if (vw < 0) begin
          vw = m_rr[s];
          m_rr[s] = (m_rr[s] + 1) % 4;
        end
        m_vld[s][vw] = 1; m_tag[s][vw] = t; m_ppn[s][vw] = p_ppn[vpn];
      end
      @(negedge clk);
      req_valid = 1'b0; flush = 1'b0;
      #1;
      chk("R3 busy drops", int'(busy), 0);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog act=1 exp=0");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    bit h;
    int r;
    for (int s = 0; s < 4; s++) begin
      m_rr[s] = 0;
      for (int w = 0; w < 4; w++) begin m_vld[s][w] = 0; m_tag[s][w] = 0; m_ppn[s][w] = 0; end
    end
    for (int i = 0; i < 256; i++) begin p_ppn[i] = 0; p_vld[i] = 0; end
    r = int'($urandom(32'd20251));

    repeat (3) @(negedge clk);
    #1;
    chk("R9 reset rsp_valid", int'(rsp_valid), 0);
    chk("R9 reset busy", int'(busy), 0);
    rst_n = 1'b1;

    // R9: empty table faults after reset
    access(14'h0123, -1, 0, h);
    chk("R9 reset miss", int'(h), 0);

    // worked case: page 0x0F -> 0x0D, PA 0x354
    pt_write(8'h0F, 6'h0D, 1);
    access(14'h03D4, -1, 0, h);
    chk("R5 first access misses", int'(h), 0);
    access(14'h03D4, -1, 0, h);
    chk("R5 refilled entry hits", int'(h), 1);

    // R11: table rewrite does not affect a cached hit
    pt_write(8'h0F, 6'h22, 1);
    access(14'h03C0, -1, 0, h);
    chk("R11 cached ppn kept", int'(h), 1);

    // R4: fault leaves cache alone
    access(14'h0400, -1, 0, h);
    access(14'h0400, -1, 0, h);
    chk("R4 faulting page misses again", int'(h), 0);

    // R6 / R7: fill set 1 beyond capacity
    for (int k = 0; k < 6; k++) pt_write(1 + 4 * k, 10 + k, 1);
    for (int k = 0; k < 4; k++) access((1 + 4 * k) * 64 + k, -1, 0, h);
    for (int k = 0; k < 4; k++) begin
      access((1 + 4 * k) * 64, -1, 0, h);
      chk("R6 free way filled", int'(h), 1);
    end
    access((1 + 4 * 4) * 64, -1, 0, h);
    access(1 * 64, -1, 0, h);
    chk("R7 way 0 evicted", int'(h), 0);
    access(5 * 64, -1, 0, h);
    chk("R7 way 1 evicted", int'(h), 0);

    // R10: request during walk is ignored
    pt_write(8'h30, 6'h15, 1);
    access(14'h0C05, 14'h0000, 0, h);
    access(14'h0000, -1, 0, h);
    chk("R10 intruder not taken", int'(h), 0);

    // R8: flush clears, and a flush in a walk cycle blocks the fill
    do_flush();
    access(14'h03D4, -1, 0, h);
    chk("R8 flushed entry misses", int'(h), 0);
    pt_write(8'h31, 6'h2A, 1);
    access(14'h0C40, -1, 1, h);
    access(14'h0C40, -1, 0, h);
    chk("R8 fill blocked by flush", int'(h), 0);
    // pointers survive flush: refill set 1 past capacity
    do_flush();
    for (int k = 0; k < 5; k++) access((1 + 4 * k) * 64, -1, 0, h);

    // random phase
    for (int n = 0; n < 500; n++) begin
      r = int'($urandom % 100);
      if (r < 10) pt_write(int'($urandom % 32), int'($urandom % 64), ($urandom % 4) != 0);
      else if (r < 13) do_flush();
      else access(int'($urandom % 32) * 64 + int'($urandom % 64), -1, 0, h);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule